// File: doc/BRIEF.md
# Stepped Voltage-Frequency Operating-Point Controller

This block keeps a core at the operating point its current workload needs. Software or a load monitor presents a requested frequency code. The controller walks the clock frequency toward that code one 33 MHz unit at a time. Around each frequency step it moves the supply voltage in 25 mV units. The frequency code drives a clock generator and the voltage code drives a regulator. Neither of those, nor the policy that picks the request, is part of this block.

Each frequency code has a minimum voltage code. These minimums live in a small register table, loaded at reset from a formula. Voltage and frequency are always changed in the order that keeps the core inside its safe region. The voltage must go up before a faster clock is applied, and the clock must come down before the voltage is reduced. After every voltage step, a programmable settle delay must pass before anything depends on it. New transitions may start no closer together than a parameterised interval. With a 5 ms interval at the reference clock, this allows at most 200 changes per second. A request that arrives mid-walk replaces the target and is followed once the current step is done.

Top module: `opp_stepper`

## Requirements
- R1: The frequency code (one unit = 33 MHz) changes by exactly +1 or -1 per transition, and changes once in each transition.
- R2: The voltage code (one unit = 25 mV) changes by exactly +1 or -1 per step. The minimum voltage for frequency code f is vmin(f) = V_BASE + i + floor(i/2), with i = f - F_MIN. With the defaults, F_MIN = 6, F_MAX = 13 and V_BASE = 20, this gives 20, 21, 23, 24, 26, 27, 29, 30.
- R3: When raising, the voltage code first steps up to vmin(f+1), and only then does the frequency code become f+1. When lowering, the frequency code steps down first, and the voltage code then steps down to vmin(f-1). At all times the voltage code is at least vmin(frequency code).
- R4: After each voltage step, at least settle_cycles_i clock cycles pass before the next voltage step or the dependent frequency step.
- R5: Two transitions start at least GAP_CYCLES clock cycles apart.
- R6: A requested code below F_MIN is treated as F_MIN, and a code above F_MAX is treated as F_MAX.
- R7: After reset, the frequency code is F_MIN, the voltage code is vmin(F_MIN) and busy_o is low.
- R8: A request accepted while a transition is in progress becomes the new target. The running transition still completes, and the walk then continues toward the new target.
- R9: busy_o is high one cycle after a transition starts. It is low whenever the frequency code equals the target and no transition is running. A request equal to the current frequency code changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Strobe: req_fcode_i carries a new target |
| req_fcode_i | input | F_W | Requested frequency code, in 33 MHz units |
| settle_cycles_i | input | SETTLE_W | Voltage settle delay, in clock cycles |
| fcode_o | output | F_W | Frequency code to the clock generator |
| vcode_o | output | V_W | Voltage code to the regulator, in 25 mV units |
| busy_o | output | 1 | The operating point is still moving toward the target |

## Verification
The main walk is driven with four patterns: a three-level climb, a full descent, a request above F_MAX and a request below F_MIN. The climb and the descent each pin down one ordering of voltage and frequency. The two out-of-range requests show whether clamping stops the walk exactly at the table ends. A reversal is issued during the settle window of an upward step. It tells a controller that abandons the running step apart from one that completes it before turning back. A request for the level already held, and a low out-of-range request made at the bottom level, must both leave every output unchanged.

// File: rtl/opp_pkg.sv
package opp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RAISE_V = 2'd1,
        ST_LOWER_F = 2'd2,
        ST_LOWER_V = 2'd3
    } opp_state_e;

    // Minimum voltage code for table index idx (idx = fcode - lowest fcode).
    function automatic int unsigned vmin_code(int unsigned idx, int unsigned vbase);
        return vbase + idx + (idx >> 1);
    endfunction

endpackage

// File: rtl/opp_clamp.sv
module opp_clamp #(
    parameter int F_W   = 5,
    parameter int F_MIN = 6,
    parameter int F_MAX = 13
) (
    input  logic [F_W-1:0] req_i,
    output logic [F_W-1:0] fcode_o
);
    localparam logic [F_W-1:0] LO = F_W'(F_MIN);
    localparam logic [F_W-1:0] HI = F_W'(F_MAX);

    always_comb begin
        if (req_i < LO)
            fcode_o = LO;
        else if (req_i > HI)
            fcode_o = HI;
        else
            fcode_o = req_i;
    end
endmodule

// File: rtl/opp_vtable.sv
module opp_vtable import opp_pkg::*; #(
    parameter int F_W    = 5,
    parameter int V_W    = 6,
    parameter int F_MIN  = 6,
    parameter int F_MAX  = 13,
    parameter int V_BASE = 20
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [F_W-1:0] fsel_i,
    output logic [V_W-1:0] vmin_o
);
    localparam int N_OPP = F_MAX - F_MIN + 1;
    localparam int IDX_W = (N_OPP > 1) ? $clog2(N_OPP) : 1;
    localparam logic [F_W-1:0] LO = F_W'(F_MIN);
    localparam logic [F_W-1:0] HI = F_W'(F_MAX);

    logic [V_W-1:0]   tab_q [N_OPP];
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_OPP; i++)
                tab_q[i] <= V_W'(vmin_code(i, V_BASE));
        end
    end

    always_comb begin
        if (fsel_i <= LO)
            idx = '0;
        else if (fsel_i >= HI)
            idx = IDX_W'(N_OPP - 1);
        else
            idx = IDX_W'(fsel_i - LO);
    end

    assign vmin_o = tab_q[idx];
endmodule

// File: rtl/opp_interval.sv
module opp_interval #(
    parameter int GAP_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= CNT_W'(GAP_CYCLES - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/opp_stepper.sv
module opp_stepper import opp_pkg::*; #(
    parameter int F_W        = 5,
    parameter int V_W        = 6,
    parameter int F_MIN      = 6,
    parameter int F_MAX      = 13,
    parameter int V_BASE     = 20,
    parameter int GAP_CYCLES = 500000,
    parameter int SETTLE_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid_i,
    input  logic [F_W-1:0]      req_fcode_i,
    input  logic [SETTLE_W-1:0] settle_cycles_i,
    output logic [F_W-1:0]      fcode_o,
    output logic [V_W-1:0]      vcode_o,
    output logic                busy_o
);
    localparam logic [F_W-1:0] F_LO  = F_W'(F_MIN);
    localparam logic [V_W-1:0] V_RST = V_W'(vmin_code(0, V_BASE));

    opp_state_e          state_q;
    logic [F_W-1:0]      fcode_q, target_q, req_clamped, vsel;
    logic [V_W-1:0]      vcode_q, vmin;
    logic [SETTLE_W-1:0] settle_q;
    logic                gap_ready, trans_start;

    opp_clamp #(.F_W(F_W), .F_MIN(F_MIN), .F_MAX(F_MAX)) u_clamp (
        .req_i   (req_fcode_i),
        .fcode_o (req_clamped)
    );

    // While raising, the voltage goal is that of the next frequency code.
    assign vsel = (state_q == ST_RAISE_V) ? fcode_q + 1'b1 : fcode_q;

    opp_vtable #(.F_W(F_W), .V_W(V_W), .F_MIN(F_MIN), .F_MAX(F_MAX),
                 .V_BASE(V_BASE)) u_vtab (
        .clk    (clk),
        .rst    (rst),
        .fsel_i (vsel),
        .vmin_o (vmin)
    );

    opp_interval #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .start_i (trans_start),
        .ready_o (gap_ready)
    );

    assign trans_start = (state_q == ST_IDLE) && gap_ready && (target_q != fcode_q);

    // Latest request wins; it is followed after the running transition.
    always_ff @(posedge clk) begin
        if (rst)
            target_q <= F_LO;
        else if (req_valid_i)
            target_q <= req_clamped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            fcode_q  <= F_LO;
            vcode_q  <= V_RST;
            settle_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (trans_start) begin
                        state_q  <= (target_q > fcode_q) ? ST_RAISE_V : ST_LOWER_F;
                        settle_q <= '0;
                    end
                end
                ST_RAISE_V: begin
                    if (settle_q != '0) begin
                        settle_q <= settle_q - 1'b1;
                    end else if (vcode_q < vmin) begin
                        vcode_q  <= vcode_q + 1'b1;
                        settle_q <= settle_cycles_i;
                    end else begin
                        fcode_q <= fcode_q + 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_LOWER_F: begin
                    fcode_q <= fcode_q - 1'b1;
                    state_q <= ST_LOWER_V;
                end
                ST_LOWER_V: begin
                    if (settle_q != '0) begin
                        settle_q <= settle_q - 1'b1;
                    end else if (vcode_q > vmin) begin
                        vcode_q  <= vcode_q - 1'b1;
                        settle_q <= settle_cycles_i;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign fcode_o = fcode_q;
    assign vcode_o = vcode_q;
    assign busy_o  = (state_q != ST_IDLE) || (target_q != fcode_q);
endmodule

// File: rtl/opp_stepper_chk.sv
module opp_stepper_chk import opp_pkg::*; #(
    parameter int F_W        = 5,
    parameter int V_W        = 6,
    parameter int F_MIN      = 6,
    parameter int F_MAX      = 13,
    parameter int V_BASE     = 20,
    parameter int GAP_CYCLES = 500000,
    parameter int SETTLE_W   = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [F_W-1:0]      fcode,
    input logic [V_W-1:0]      vcode,
    input logic [SETTLE_W-1:0] settle_cycles,
    input logic                start,
    input logic                busy
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 1);
    localparam logic [F_W-1:0]   F_LO  = F_W'(F_MIN);
    localparam logic [F_W-1:0]   F_HI  = F_W'(F_MAX);
    localparam logic [CNT_W-1:0] GAP_C = CNT_W'(GAP_CYCLES);

    logic [CNT_W-1:0]    since_start;
    logic [SETTLE_W-1:0] since_v;
    logic [V_W-1:0]      prev_v;
    logic [V_W-1:0]      vmin_now;

    assign vmin_now = V_W'(vmin_code(int'(fcode - F_LO), V_BASE));

    always_ff @(posedge clk) begin
        if (rst) begin
            since_start <= GAP_C;
            since_v     <= '1;
            prev_v      <= V_W'(vmin_code(0, V_BASE));
        end else begin
            prev_v <= vcode;
            if (start)
                since_start <= CNT_W'(1);
            else if (since_start < GAP_C)
                since_start <= since_start + 1'b1;
            if (vcode != prev_v)
                since_v <= '0;
            else if (since_v != '1)
                since_v <= since_v + 1'b1;
        end
    end

    p_fstep_r1: assert property (@(posedge clk) disable iff (rst)
        (fcode != $past(fcode)) |->
        (fcode == $past(fcode) + 1'b1 || fcode == $past(fcode) - 1'b1));

    p_vstep_r2: assert property (@(posedge clk) disable iff (rst)
        (vcode != $past(vcode)) |->
        (vcode == $past(vcode) + 1'b1 || vcode == $past(vcode) - 1'b1));

    p_vsafe_r3: assert property (@(posedge clk) disable iff (rst)
        vcode >= vmin_now);

    p_settle_r4: assert property (@(posedge clk) disable iff (rst)
        (fcode > $past(fcode)) |-> (since_v >= settle_cycles));

    p_gap_r5: assert property (@(posedge clk) disable iff (rst)
        start |-> (since_start >= GAP_C));

    p_range_r6: assert property (@(posedge clk) disable iff (rst)
        (fcode >= F_LO) && (fcode <= F_HI));

    p_busy_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
endmodule

bind opp_stepper opp_stepper_chk #(
    .F_W(F_W), .V_W(V_W), .F_MIN(F_MIN), .F_MAX(F_MAX), .V_BASE(V_BASE),
    .GAP_CYCLES(GAP_CYCLES), .SETTLE_W(SETTLE_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .fcode         (fcode_o),
    .vcode         (vcode_o),
    .settle_cycles (settle_cycles_i),
    .start         (trans_start),
    .busy          (busy_o)
);

// File: tb/sim_opp_stepper.sv
module sim_opp_stepper;
    localparam int F_W = 5, V_W = 6, F_MIN = 6, F_MAX = 13, V_BASE = 20;
    localparam int GAP = 300, SW = 8, SETTLE = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic [F_W-1:0] req_fcode = '0;
    logic [SW-1:0]  settle = SW'(SETTLE);
    logic [F_W-1:0] fcode;
    logic [V_W-1:0] vcode;
    logic           busy;

    opp_stepper #(.F_W(F_W), .V_W(V_W), .F_MIN(F_MIN), .F_MAX(F_MAX),
                  .V_BASE(V_BASE), .GAP_CYCLES(GAP), .SETTLE_W(SW)) u0 (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_fcode_i(req_fcode),
        .settle_cycles_i(settle), .fcode_o(fcode), .vcode_o(vcode), .busy_o(busy)
    );

    typedef struct packed {
        logic [F_W-1:0] f;
        logic [V_W-1:0] v;
        logic           first;
    } item_t;

    item_t exp_q[$];
    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int vt(int f);
        int i = f - F_MIN;
        return V_BASE + i + i / 2;
    endfunction

    task automatic push_walk(int from, int to);
        int f = from;
        while (f < to) begin
            for (int v = vt(f) + 1; v <= vt(f + 1); v++)
                exp_q.push_back('{F_W'(f), V_W'(v), v == vt(f) + 1});
            exp_q.push_back('{F_W'(f + 1), V_W'(vt(f + 1)), 1'b0});
            f++;
        end
        while (f > to) begin
            exp_q.push_back('{F_W'(f - 1), V_W'(vt(f)), 1'b1});
            for (int v = vt(f) - 1; v >= vt(f - 1); v--)
                exp_q.push_back('{F_W'(f - 1), V_W'(v), 1'b0});
            f--;
        end
    endtask

    // Monitor: pops one expected item per observed output change.
    logic [F_W-1:0] pf;
    logic [V_W-1:0] pv;
    int  last_chg = 0, last_first = 0;
    bit  have_first = 0, last_was_v = 0;
    item_t it;
    always @(negedge clk) begin
        if (rst) begin
            pf = fcode; pv = vcode;
        end else if (fcode != pf || vcode != pv) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: unexpected change f=%0d v=%0d, expected none", fcode, vcode);
            end else begin
                it = exp_q.pop_front();
                checks++;
                if (fcode != it.f || vcode != it.v) begin
                    errors++;
                    $display("FAIL R1/R2/R3: point f=%0d v=%0d, expected f=%0d v=%0d",
                             fcode, vcode, it.f, it.v);
                end
                checks++;
                if (int'(vcode) < vt(int'(fcode))) begin
                    errors++;
                    $display("FAIL R3: v=%0d below minimum, expected >= %0d", vcode, vt(int'(fcode)));
                end
                if (it.first) begin
                    if (have_first) begin
                        checks++;
                        if (cyc - last_first < GAP) begin
                            errors++;
                            $display("FAIL R5: transition spacing %0d, expected >= %0d",
                                     cyc - last_first, GAP);
                        end
                    end
                    last_first = cyc; have_first = 1;
                end else if (last_was_v) begin
                    checks++;
                    if (cyc - last_chg < SETTLE) begin
                        errors++;
                        $display("FAIL R4: settle spacing %0d, expected >= %0d",
                                 cyc - last_chg, SETTLE);
                    end
                end
            end
            last_was_v = (vcode != pv);
            last_chg = cyc;
            pf = fcode; pv = vcode;
        end
    end

    task automatic request(int code);
        @(negedge clk);
        req_valid = 1'b1; req_fcode = F_W'(code);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(string tag);
        int t = 0;
        repeat (2) @(negedge clk);
        while ((exp_q.size() != 0 || busy) && t < 20000) begin
            @(negedge clk); t++;
        end
        checks++;
        if (t >= 20000) begin
            errors++;
            $display("FAIL %s: walk did not finish, queue=%0d busy=%0b, expected 0/0",
                     tag, exp_q.size(), busy);
        end
    endtask

    task automatic check_point(string tag, int f);
        checks++;
        if (fcode != F_W'(f) || vcode != V_W'(vt(f)) || busy !== 1'b0) begin
            errors++;
            $display("FAIL %s: f=%0d v=%0d busy=%0b, expected f=%0d v=%0d busy=0",
                     tag, fcode, vcode, busy, f, vt(f));
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check_point("R7 reset", F_MIN);
        rst = 1'b0;
        @(negedge clk);
        check_point("R7 after reset", F_MIN);

        // R1 R2 R3 R4: climb three levels
        push_walk(6, 9);
        request(9);
        checks++;
        if (busy !== 1'b1) begin
            errors++;
            $display("FAIL R9: busy=%0b after request, expected 1", busy);
        end
        wait_idle("R3 climb");
        check_point("R1 climb end", 9);

        // R5 R3: full descent
        push_walk(9, 6);
        request(6);
        wait_idle("R3 descent");
        check_point("R2 descent end", 6);

        // R6: request above the top clamps to F_MAX
        push_walk(6, F_MAX);
        request(31);
        wait_idle("R6 high");
        check_point("R6 clamp high", F_MAX);

        // R6: request below the bottom clamps to F_MIN
        push_walk(F_MAX, F_MIN);
        request(0);
        wait_idle("R6 low");
        check_point("R6 clamp low", F_MIN);

        // R8: reversal during the settle window of an upward step
        push_walk(6, 7);
        push_walk(7, 6);
        request(7);
        for (int t = 0; t < 2000 && vcode == V_W'(vt(6)); t++) @(negedge clk);
        checks++;
        if (fcode != 5'd6) begin
            errors++;
            $display("FAIL R3: f=%0d moved before voltage, expected 6", fcode);
        end
        request(6);
        wait_idle("R8 reversal");
        check_point("R8 reversal end", 6);

        // R9 R6: same-level and low out-of-range requests change nothing
        request(6);
        check_point("R9 same level", 6);
        request(2);
        check_point("R6 low at bottom", 6);
        repeat (2 * GAP) @(negedge clk);
        check_point("R9 no change", 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule